// File: doc/BRIEF.md
# SPI Master Chip-Select Sequencer

This block is the master side of an SPI link with four active-low chip-select outputs. Software places one 8-bit word and a 2-bit peripheral index into a single-entry holding register. The block moves that word into a shifter and clocks it out in SPI mode 0 (SCK idles low, MOSI changes on falling edges, MISO is sampled on rising edges, MSB first). While the word shifts, the holding register is free again, so software can stage the next word.

Each peripheral has its own configuration entry, selected by the index that travels with the word. An entry holds three things. A hold bit keeps the chip select low between words until a different peripheral is addressed. A post-transfer delay is inserted after every word. A select-gap delay keeps every line high for a while before that peripheral is selected. Bursts to one peripheral can therefore run with gaps between words and without glitches on its select line.

The block also watches a shared slave-select input. If an external master pulls that input low while the block is enabled and is not itself driving peripheral 0's line, the block records a mode fault. It then aborts the transfer, releases all selects and disables itself until software clears the fault and enables it again.

Top module: `spi_cs_sequencer`

## Requirements
- R1: After reset, cs_n is 4'b1111, sck is 0, tx_empty is 1, mode_fault is 0 and enabled is 0.
- R2: Bit i of cs_n low selects peripheral i, and at most one bit is ever low. For a peripheral whose hold bit is 0, all lines go high once its post-transfer delay ends and no word for the same peripheral is pending.
- R3: For a peripheral whose hold bit is 1, its line stays low after the post-transfer delay, including across idle gaps. It goes high only when a word for a different peripheral is taken up.
- R4: If a word for the current peripheral is pending when the post-transfer delay ends, the next word starts with the chip select held low. A burst of such words shows one select assertion.
- R5: Every chip-select assertion is preceded by exactly dly_sel+1 clock cycles with all lines high, using the dly_sel of the peripheral being selected. This is counted from the cycle after the deselect when switching away from a held peripheral.
- R6: Shifting is SPI mode 0 with 8 bits, MSB first. Each SCK half-period is SCK_DIV clock cycles, SCK stays low outside a transfer, and MOSI changes only on SCK falling edges.
- R7: MISO is sampled on every SCK rising edge. rx_valid pulses for one cycle in the cycle after the last falling edge, and rx_data then holds the 8 received bits, first bit in the MSB.
- R8: tx_empty drops the cycle after a write is accepted and rises at the edge where the word moves into the shifter. A write while tx_empty is 0 is ignored.
- R9: A mode fault occurs when enabled is 1, ss_n_in is low and cs_n[0] is high. On the next cycle mode_fault is 1, enabled is 0, all cs_n lines are high, sck is 0 and any pending word is discarded. With cs_n[0] low, ss_n_in low has no effect.
- R10: While mode_fault is 1, enable_set is ignored. fault_clr clears the fault, and enable_set afterwards resumes operation.
- R11: Each peripheral's hold bit, post-transfer delay (dly_xfer+1 cycles) and select gap come from its own configuration entry. A write to one entry leaves the other entries unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_set | input | 1 | Strobe that enables the sequencer |
| fault_clr | input | 1 | Strobe that clears the mode fault |
| cfg_we | input | 1 | Configuration entry write strobe |
| cfg_idx | input | 2 | Entry selected by cfg_we |
| cfg_hold | input | 1 | Hold-after-transfer bit for the entry |
| cfg_dly_xfer | input | 8 | Post-transfer delay, cycles minus one |
| cfg_dly_sel | input | 8 | Select gap, cycles minus one |
| tx_we | input | 1 | Holding-register write strobe |
| tx_data | input | 8 | Word to send |
| tx_idx | input | 2 | Target peripheral of the word |
| tx_empty | output | 1 | Holding register free |
| enabled | output | 1 | Sequencer enabled |
| mode_fault | output | 1 | Mode fault flag |
| ss_n_in | input | 1 | Shared slave-select input |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low chip selects |
| rx_valid | output | 1 | Received word valid pulse |
| rx_data | output | 8 | Received word |

## Verification
A cycle-accurate model in the bench is compared with every output on every clock. Four patterns are used. A gap-free burst to a non-holding peripheral, started with an ignored extra write, separates continuation from reselection. Spaced words to a holding peripheral and a switch to another holding peripheral separate hold from release and check the exact length of the select gap. A fault injected during a transfer to peripheral 2 and a low slave-select during a transfer to peripheral 0 separate a real fault from the block's own select. MISO carries a pseudo-random stream, so sampling on the wrong edge or in the wrong order shows up in rx_data.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_GAP     = 2'd1,
    ST_SHIFT   = 2'd2,
    ST_HOLDOFF = 2'd3
  } seq_state_t;

  // Another master drives the shared select while this block is not driving line 0
  function automatic logic is_mode_fault(input logic en, input logic ss_n, input logic cs0_n);
    return en & ~ss_n & cs0_n;
  endfunction

endpackage

// File: rtl/spi_cfg_bank.sv
module spi_cfg_bank #(
  parameter int NUM_CS = 4,
  parameter int DLY_W  = 8,
  parameter int IDX_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [IDX_W-1:0]        idx,
  input  logic                    hold,
  input  logic [DLY_W-1:0]        dly_xfer,
  input  logic [DLY_W-1:0]        dly_sel,
  output logic [NUM_CS-1:0]       hold_vec,
  output logic [NUM_CS*DLY_W-1:0] xfer_vec,
  output logic [NUM_CS*DLY_W-1:0] sel_vec
);

  for (genvar g = 0; g < NUM_CS; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hold_vec[g]                 <= 1'b0;
        xfer_vec[g*DLY_W +: DLY_W]  <= '0;
        sel_vec[g*DLY_W +: DLY_W]   <= '0;
      end else if (we && idx == IDX_W'(g)) begin
        hold_vec[g]                 <= hold;
        xfer_vec[g*DLY_W +: DLY_W]  <= dly_xfer;
        sel_vec[g*DLY_W +: DLY_W]   <= dly_sel;
      end
    end
  end

endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine #(
  parameter int DATA_W  = 8,
  parameter int SCK_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic [DATA_W-1:0] word,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              done,
  output logic [DATA_W-1:0] rx_word
);

  localparam int DIV_W = (SCK_DIV > 1) ? $clog2(SCK_DIV) : 1;
  localparam int BIT_W = $clog2(DATA_W);

  logic [DIV_W-1:0]  div_q;
  logic [BIT_W-1:0]  bit_q;
  logic [DATA_W-1:0] tx_sh, rx_sh;
  logic              busy_q, sck_q;
  logic              tick;

  assign tick    = busy_q && (div_q == DIV_W'(SCK_DIV - 1));
  assign done    = tick && sck_q && (bit_q == BIT_W'(DATA_W - 1));
  assign sck     = sck_q;
  assign mosi    = busy_q & tx_sh[DATA_W-1];
  assign rx_word = rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      bit_q  <= '0;
      tx_sh  <= '0;
      rx_sh  <= '0;
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
    end else if (abort) begin
      div_q  <= '0;
      bit_q  <= '0;
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
    end else if (start) begin
      tx_sh  <= word;
      div_q  <= '0;
      bit_q  <= '0;
      busy_q <= 1'b1;
      sck_q  <= 1'b0;
    end else if (busy_q) begin
      if (tick) begin
        div_q <= '0;
        sck_q <= ~sck_q;
        if (!sck_q) begin
          rx_sh <= {rx_sh[DATA_W-2:0], miso};
        end else begin
          tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
          bit_q <= bit_q + 1'b1;
          if (done) busy_q <= 1'b0;
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/spi_cs_fsm.sv
module spi_cs_fsm
  import spi_cs_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int DLY_W  = 8,
  parameter int IDX_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    abort,
  input  logic                    tx_full,
  input  logic [IDX_W-1:0]        tx_idx,
  input  logic [NUM_CS-1:0]       hold_vec,
  input  logic [NUM_CS*DLY_W-1:0] xfer_vec,
  input  logic [NUM_CS*DLY_W-1:0] sel_vec,
  input  logic                    xfer_done,
  output logic                    start,
  output logic                    cs_active,
  output logic [IDX_W-1:0]        cur_idx,
  output seq_state_t              state
);

  logic [DLY_W-1:0] cnt_q;
  logic             hold_cur;
  logic [DLY_W-1:0] xfer_cur;
  logic [DLY_W-1:0] sel_new;
  logic             same_peri;
  logic             cnt_zero;

  assign hold_cur  = hold_vec[cur_idx];
  assign xfer_cur  = xfer_vec[cur_idx*DLY_W +: DLY_W];
  assign sel_new   = sel_vec[tx_idx*DLY_W +: DLY_W];
  assign same_peri = (tx_idx == cur_idx);
  assign cnt_zero  = (cnt_q == '0);

  always_comb begin
    start = 1'b0;
    if (!abort) begin
      case (state)
        ST_IDLE:    start = en && tx_full && cs_active && same_peri;
        ST_GAP:     start = cnt_zero;
        ST_HOLDOFF: start = cnt_zero && tx_full && same_peri;
        default:    start = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt_q     <= '0;
      cs_active <= 1'b0;
      cur_idx   <= '0;
    end else if (abort) begin
      state     <= ST_IDLE;
      cnt_q     <= '0;
      cs_active <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (en && tx_full) begin
            if (cs_active && same_peri) begin
              state <= ST_SHIFT;
            end else begin
              cs_active <= 1'b0;
              cnt_q     <= sel_new;
              state     <= ST_GAP;
            end
          end
        end
        ST_GAP: begin
          if (cnt_zero) begin
            state     <= ST_SHIFT;
            cs_active <= 1'b1;
            cur_idx   <= tx_idx;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_SHIFT: begin
          if (xfer_done) begin
            state <= ST_HOLDOFF;
            cnt_q <= xfer_cur;
          end
        end
        ST_HOLDOFF: begin
          if (cnt_zero) begin
            if (tx_full && same_peri) begin
              state <= ST_SHIFT;
            end else begin
              if (!hold_cur) cs_active <= 1'b0;
              state <= ST_IDLE;
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_cs_sequencer.sv
module spi_cs_sequencer
  import spi_cs_pkg::*;
#(
  parameter int NUM_CS  = 4,
  parameter int DATA_W  = 8,
  parameter int DLY_W   = 8,
  parameter int SCK_DIV = 2,
  localparam int IDX_W  = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable_set,
  input  logic              fault_clr,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_hold,
  input  logic [DLY_W-1:0]  cfg_dly_xfer,
  input  logic [DLY_W-1:0]  cfg_dly_sel,
  input  logic              tx_we,
  input  logic [DATA_W-1:0] tx_data,
  input  logic [IDX_W-1:0]  tx_idx,
  output logic              tx_empty,
  output logic              enabled,
  output logic              mode_fault,
  input  logic              ss_n_in,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] cs_n,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data
);

  logic                    en_q, fault_q, full_q;
  logic [DATA_W-1:0]       hold_word;
  logic [IDX_W-1:0]        hold_idx;
  logic [NUM_CS-1:0]       hold_vec;
  logic [NUM_CS*DLY_W-1:0] xfer_vec, sel_vec;
  logic                    load_evt, fault_evt, xfer_done;
  logic                    cs_active;
  logic [IDX_W-1:0]        cur_idx;
  logic [DATA_W-1:0]       rx_word;
  seq_state_t              state;

  assign fault_evt  = is_mode_fault(en_q, ss_n_in, cs_n[0]);
  assign tx_empty   = ~full_q;
  assign enabled    = en_q;
  assign mode_fault = fault_q;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_csdec
    assign cs_n[g] = ~(cs_active && (cur_idx == IDX_W'(g)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      fault_q <= 1'b0;
    end else if (fault_evt) begin
      en_q    <= 1'b0;
      fault_q <= 1'b1;
    end else begin
      if (fault_clr) fault_q <= 1'b0;
      if (enable_set && !fault_q) en_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q    <= 1'b0;
      hold_word <= '0;
      hold_idx  <= '0;
    end else if (fault_evt || load_evt) begin
      full_q <= 1'b0;
    end else if (tx_we && !full_q) begin
      full_q    <= 1'b1;
      hold_word <= tx_data;
      hold_idx  <= tx_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      rx_valid <= xfer_done & ~fault_evt;
      if (xfer_done && !fault_evt) rx_data <= rx_word;
    end
  end

  spi_cfg_bank #(.NUM_CS(NUM_CS), .DLY_W(DLY_W), .IDX_W(IDX_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_idx), .hold(cfg_hold),
    .dly_xfer(cfg_dly_xfer), .dly_sel(cfg_dly_sel),
    .hold_vec(hold_vec), .xfer_vec(xfer_vec), .sel_vec(sel_vec)
  );

  spi_cs_fsm #(.NUM_CS(NUM_CS), .DLY_W(DLY_W), .IDX_W(IDX_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .en(en_q), .abort(fault_evt), .tx_full(full_q),
    .tx_idx(hold_idx), .hold_vec(hold_vec), .xfer_vec(xfer_vec), .sel_vec(sel_vec),
    .xfer_done(xfer_done), .start(load_evt), .cs_active(cs_active),
    .cur_idx(cur_idx), .state(state)
  );

  spi_bit_engine #(.DATA_W(DATA_W), .SCK_DIV(SCK_DIV)) u_bits (
    .clk(clk), .rst_n(rst_n), .start(load_evt), .abort(fault_evt), .word(hold_word),
    .miso(miso), .sck(sck), .mosi(mosi), .done(xfer_done), .rx_word(rx_word)
  );

endmodule

// File: rtl/spi_cs_sequencer_chk.sv
module spi_cs_sequencer_chk
  import spi_cs_pkg::*;
#(
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CS-1:0] cs_n,
  input logic              sck,
  input logic              tx_empty,
  input logic              enabled,
  input logic              mode_fault,
  input logic              load_evt,
  input logic              fault_evt,
  input seq_state_t        state
);

  // R2: never more than one select low
  a_r2_single_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  // R5: every line high while the select gap runs
  a_r5_gap_all_high: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_GAP) |-> (&cs_n));

  // R6: serial clock parked low outside a shift
  a_r6_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_SHIFT) |-> !sck);

  // R3: select line does not move while a word shifts
  a_r3_select_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SHIFT && !fault_evt) |=> $stable(cs_n));

  // R8: holding register freed by the move into the shifter
  a_r8_empty_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> tx_empty);

  // R9: fault releases everything and disables
  a_r9_fault_release: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> ((&cs_n) && !sck && mode_fault && !enabled));

  // R10: no enable while the fault stands
  a_r10_fault_blocks_enable: assert property (@(posedge clk) disable iff (!rst_n)
    mode_fault |-> !enabled);

endmodule

bind spi_cs_sequencer spi_cs_sequencer_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .tx_empty(tx_empty),
  .enabled(enabled), .mode_fault(mode_fault), .load_evt(load_evt),
  .fault_evt(fault_evt), .state(state)
);

// File: tb/spi_cs_sequencer_tb.sv
module spi_cs_sequencer_tb;

  localparam int DIV = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable_set = 0, fault_clr = 0, cfg_we = 0, cfg_hold = 0, tx_we = 0;
  logic [1:0] cfg_idx = 0, tx_idx = 0;
  logic [7:0] cfg_dly_xfer = 0, cfg_dly_sel = 0, tx_data = 0;
  logic       ss_n_in = 1'b1, miso = 1'b0;
  logic       tx_empty, enabled, mode_fault, sck, mosi, rx_valid;
  logic [3:0] cs_n;
  logic [7:0] rx_data;

  int checks = 0, fails = 0, cyc = 0;

  spi_cs_sequencer #(.SCK_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable_set(enable_set), .fault_clr(fault_clr),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_hold(cfg_hold),
    .cfg_dly_xfer(cfg_dly_xfer), .cfg_dly_sel(cfg_dly_sel),
    .tx_we(tx_we), .tx_data(tx_data), .tx_idx(tx_idx), .tx_empty(tx_empty),
    .enabled(enabled), .mode_fault(mode_fault), .ss_n_in(ss_n_in),
    .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n),
    .rx_valid(rx_valid), .rx_data(rx_data)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int   m_st, m_cnt, m_cur, m_idx, m_t;
  bit   m_act, m_en, m_fault, m_full, m_busy, m_rxv;
  logic [7:0] m_word, m_sh, m_rx, m_rxd;
  int   c_hold[4], c_dx[4], c_ds[4];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_cur = 0; m_idx = 0; m_t = 0;
      m_act = 0; m_en = 0; m_fault = 0; m_full = 0; m_busy = 0; m_rxv = 0;
      m_word = 0; m_sh = 0; m_rx = 0; m_rxd = 0;
      for (int i = 0; i < 4; i++) begin c_hold[i] = 0; c_dx[i] = 0; c_ds[i] = 0; end
    end else begin
      automatic bit o_act = m_act, o_en = m_en, o_fault = m_fault, o_full = m_full, o_busy = m_busy;
      automatic int o_cur = m_cur, o_st = m_st, o_cnt = m_cnt, o_t = m_t;
      automatic bit fz = o_en && !ss_n_in && !(o_act && o_cur == 0);
      automatic bit done = 0, start = 0;
      m_rxv = 0;
      if (fz) begin
        m_fault = 1; m_en = 0; m_st = 0; m_act = 0; m_cnt = 0;
        m_full = 0; m_busy = 0; m_t = 0;
      end else begin
        if (fault_clr) m_fault = 0;
        if (enable_set && !o_fault) m_en = 1;
        if (o_busy) begin
          m_t = o_t + 1;
          if (m_t % (2*DIV) == DIV) m_rx = {m_rx[6:0], miso};
          if (m_t == 16*DIV) begin done = 1; m_busy = 0; m_rxv = 1; m_rxd = m_rx; end
        end
        case (o_st)
          0: if (o_en && o_full) begin
               if (o_act && o_cur == m_idx) begin start = 1; m_st = 2; end
               else begin m_act = 0; m_cnt = c_ds[m_idx]; m_st = 1; end
             end
          1: if (o_cnt == 0) begin start = 1; m_st = 2; m_act = 1; m_cur = m_idx; end
             else m_cnt = o_cnt - 1;
          2: if (done) begin m_st = 3; m_cnt = c_dx[o_cur]; end
          default: if (o_cnt == 0) begin
               if (o_full && m_idx == o_cur) begin start = 1; m_st = 2; end
               else begin if (c_hold[o_cur] == 0) m_act = 0; m_st = 0; end
             end else m_cnt = o_cnt - 1;
        endcase
        if (start) begin m_busy = 1; m_t = 0; m_sh = m_word; m_full = 0; end
        else if (tx_we && !o_full) begin m_full = 1; m_word = tx_data; m_idx = int'(tx_idx); end
      end
      if (cfg_we) begin
        c_hold[cfg_idx] = int'(cfg_hold); c_dx[cfg_idx] = int'(cfg_dly_xfer); c_ds[cfg_idx] = int'(cfg_dly_sel);
      end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      automatic logic [3:0] e_cs = m_act ? ~(4'b1 << m_cur) : 4'hF;
      automatic logic e_sck = m_busy && (((m_t / DIV) % 2) == 1);
      automatic logic e_mosi = m_busy ? m_sh[7 - (m_t / (2*DIV))] : 1'b0;
      chk("R2/R3/R4/R5/R11", "cs_n", cs_n, e_cs);
      chk("R6", "sck", sck, e_sck);
      chk("R6", "mosi", mosi, e_mosi);
      chk("R8", "tx_empty", tx_empty, !m_full);
      chk("R7", "rx_valid", rx_valid, m_rxv);
      chk("R7", "rx_data", rx_data, m_rxd);
      chk("R9", "mode_fault", mode_fault, m_fault);
      chk("R10", "enabled", enabled, m_en);
    end
  end

  // miso stream and slave-side capture of mosi
  logic [7:0] lfsr = 8'h5B;
  logic       sck_prev = 0;
  logic [7:0] cap = 0;
  int         cap_n = 0, high_run = 0, last_run = 0, sel_count = 0;
  logic [3:0] cs_prev = 4'hF;
  logic [7:0] capq[$];

  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    miso <= lfsr[0];
    if (sck && !sck_prev) begin
      cap = {cap[6:0], mosi};
      cap_n++;
      if (cap_n == 8) begin capq.push_back(cap); cap_n = 0; end
    end
    if (cs_n == 4'hF) begin cap_n = 0; high_run++; end
    else begin
      if (cs_prev == 4'hF) begin last_run = high_run; sel_count++; end
      high_run = 0;
    end
    sck_prev = sck;
    cs_prev  = cs_n;
  end

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_enable();
    enable_set = 1; @(negedge clk); enable_set = 0;
  endtask

  task automatic set_cfg(input int i, input bit h, input int dx, input int ds);
    cfg_we = 1; cfg_idx = 2'(i); cfg_hold = h; cfg_dly_xfer = 8'(dx); cfg_dly_sel = 8'(ds);
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic send(input int i, input logic [7:0] d);
    int guard = 0;
    while (!tx_empty && guard < 500) begin @(negedge clk); guard++; end
    tx_we = 1; tx_idx = 2'(i); tx_data = d;
    @(negedge clk); tx_we = 0;
  endtask

  task automatic wait_cs(input logic [3:0] v);
    int guard = 0;
    while (cs_n !== v && guard < 500) begin @(negedge clk); guard++; end
  endtask

  initial begin
    cycles(5);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "cs_n reset", cs_n, 4'hF);
    chk("R1", "sck reset", sck, 0);
    chk("R1", "tx_empty reset", tx_empty, 1);
    chk("R1", "mode_fault reset", mode_fault, 0);
    chk("R1", "enabled reset", enabled, 0);

    // R11: distinct entries per peripheral
    set_cfg(0, 0, 2, 1);
    set_cfg(1, 1, 0, 3);
    set_cfg(2, 0, 5, 0);
    set_cfg(3, 1, 1, 2);

    // R8: second write while full is dropped
    tx_we = 1; tx_idx = 0; tx_data = 8'hA5; @(negedge clk);
    tx_data = 8'h3C; @(negedge clk); tx_we = 0;
    cycles(4);
    chk("R8", "tx_empty held while disabled", tx_empty, 0);
    pulse_enable();
    // R4: burst to peripheral 0 without select release
    send(0, 8'h5A);
    send(0, 8'hC3);
    cycles(150);
    chk("R2", "cs released after hold=0 burst", cs_n, 4'hF);
    chk("R4", "one select for burst", sel_count, 1);
    chk("R8", "bytes captured", capq.size(), 3);
    if (capq.size() == 3) begin
      chk("R6", "first byte msb first", capq[0], 8'hA5);
      chk("R4", "second byte", capq[1], 8'h5A);
      chk("R4", "third byte", capq[2], 8'hC3);
    end

    // R3: hold across gaps
    send(1, 8'h11);
    cycles(60);
    chk("R3", "p1 held after first word", cs_n, 4'b1101);
    send(1, 8'h22);
    cycles(60);
    chk("R3", "p1 held after second word", cs_n, 4'b1101);
    chk("R3", "p1 selected once", sel_count, 2);

    // R5: switch to peripheral 3, gap of dly_sel+1 = 3 cycles
    send(3, 8'h33);
    cycles(60);
    chk("R5", "select gap before p3", last_run, 3);
    chk("R3", "p3 held", cs_n, 4'b0111);
    chk("R6", "p3 byte", capq[capq.size()-1], 8'h33);

    // R9: fault during transfer to peripheral 2
    send(2, 8'h44);
    wait_cs(4'b1011);
    cycles(5);
    ss_n_in = 0; @(negedge clk); ss_n_in = 1;
    chk("R9", "fault flagged", mode_fault, 1);
    chk("R9", "selects released", cs_n, 4'hF);
    chk("R9", "sck low", sck, 0);
    chk("R9", "disabled", enabled, 0);

    // R10: enable ignored while faulted
    pulse_enable();
    send(0, 8'h77);
    cycles(40);
    chk("R10", "still disabled", enabled, 0);
    chk("R10", "no select while faulted", cs_n, 4'hF);
    fault_clr = 1; @(negedge clk); fault_clr = 0;
    pulse_enable();
    cycles(80);
    chk("R10", "fault cleared", mode_fault, 0);
    chk("R10", "pending word sent after re-enable", capq[capq.size()-1], 8'h77);
    chk("R2", "p0 released", cs_n, 4'hF);

    // R9: own select on line 0 masks the slave-select input
    send(0, 8'h88);
    wait_cs(4'b1110);
    cycles(2);
    ss_n_in = 0; cycles(3); ss_n_in = 1;
    chk("R9", "no fault while driving line 0", mode_fault, 0);
    cycles(60);
    chk("R7", "p0 byte after masked select", capq[capq.size()-1], 8'h88);

    summary();
    $finish;
  end

endmodule